// File: doc/BRIEF.md
# Instruction immediate extractor

This block pulls the immediate operand out of a 32-bit base-integer instruction word and returns it as a 32-bit value. It is purely combinational. The control decoder tells it which layout the word uses through a 3-bit format code. The datapath takes the result as the second operand of the adder, or as a PC-relative offset.

Five layouts are covered:

- register-immediate (I)
- store (S)
- conditional branch (B)
- upper-immediate (U)
- jump (J)

The sign of every sign-extended result comes from instruction bit 31. Most result bits are wired to one fixed instruction bit whatever the layout. Branch and jump offsets are built by moving single bits into place, not by shifting a whole field. Only a handful of result bits therefore need a real multiplexer.

Top module: `imm_extract`

## Requirements
- R1: With format code 0 (I), imm_out[11:0] equals instr_word[31:20] and imm_out[31:12] all equal instr_word[31].
- R2: With format code 1 (S), imm_out[11:5] equals instr_word[31:25], imm_out[4:0] equals instr_word[11:7], and imm_out[31:12] all equal instr_word[31].
- R3: With format code 2 (B), imm_out[0] is 0, imm_out[4:1] equals instr_word[11:8], imm_out[10:5] equals instr_word[30:25], imm_out[11] equals instr_word[7], and imm_out[31:12] all equal instr_word[31]. The offset therefore spans -4096 to +4094 in steps of 2.
- R4: With format code 4 (J), imm_out[0] is 0, imm_out[10:1] equals instr_word[30:21], imm_out[11] equals instr_word[20], imm_out[19:12] equals instr_word[19:12], and imm_out[31:20] all equal instr_word[31]. The offset therefore spans -1048576 to +1048574.
- R5: With format code 3 (U), imm_out[31:12] equals instr_word[31:12] and imm_out[11:0] is zero.
- R6: For format codes 0, 1, 2 and 4, imm_out[31:20] is a copy of instr_word[31].
- R7: Format codes 5, 6 and 7 give imm_out equal to zero, whatever the instruction word.
- R8: The block holds no state. imm_out reflects the current instr_word and fmt_sel in the same cycle.
- R9: For format codes 0, 1, 2 and 4, imm_out[10:5] equals instr_word[30:25].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word being decoded |
| fmt_sel | input | 3 | Layout code: 0=I, 1=S, 2=B, 3=U, 4=J, others unused |
| imm_out | output | 32 | Extracted, extended immediate |

## Verification
Every result is due zero cycles after its stimulus, because the block has no registers. The bench changes instr_word and fmt_sel on the falling clock edge and compares imm_out one nanosecond later, well before the next rising edge. Each comparison therefore sees the response to the vector just applied and nothing older. Random words and codes, including the unused codes, are mixed with directed words at the extreme positive and negative offsets of each layout.

// File: rtl/imm_extract.sv
module imm_extract (
  input  logic [31:0] instr_word,
  input  logic [2:0]  fmt_sel,
  output logic [31:0] imm_out
);

  localparam logic [2:0] FMT_I = 3'd0;
  localparam logic [2:0] FMT_S = 3'd1;
  localparam logic [2:0] FMT_B = 3'd2;
  localparam logic [2:0] FMT_U = 3'd3;
  localparam logic [2:0] FMT_J = 3'd4;

  logic sgn;
  logic is_i, is_s, is_b, is_u, is_j, signed_fmt;

  assign sgn        = instr_word[31];
  assign is_i       = (fmt_sel == FMT_I);
  assign is_s       = (fmt_sel == FMT_S);
  assign is_b       = (fmt_sel == FMT_B);
  assign is_u       = (fmt_sel == FMT_U);
  assign is_j       = (fmt_sel == FMT_J);
  assign signed_fmt = is_i | is_s | is_b | is_j;

  logic [11:0] hi_seg;
  logic [7:0]  mid_seg;
  logic        b11;
  logic [5:0]  b10_5;
  logic [3:0]  b4_1;
  logic        b0;

  assign hi_seg  = is_u       ? instr_word[31:20] :
                   signed_fmt ? {12{sgn}}         : 12'd0;

  assign mid_seg = (is_u | is_j)        ? instr_word[19:12] :
                   (is_i | is_s | is_b) ? {8{sgn}}          : 8'd0;

  always_comb begin
    unique case (1'b1)
      is_i, is_s: b11 = sgn;
      is_b:       b11 = instr_word[7];
      is_j:       b11 = instr_word[20];
      default:    b11 = 1'b0;
    endcase
  end

  assign b10_5 = signed_fmt ? instr_word[30:25] : 6'd0;

  assign b4_1  = (is_i | is_j) ? instr_word[24:21] :
                 (is_s | is_b) ? instr_word[11:8]  : 4'd0;

  assign b0    = is_i ? instr_word[20] :
                 is_s ? instr_word[7]  : 1'b0;

  assign imm_out = {hi_seg, mid_seg, b11, b10_5, b4_1, b0};

  always_comb begin
    if (signed_fmt)
      AST_SIGN_FILL: assert (imm_out[31:20] == {12{instr_word[31]}}); // R6
    if (is_b || is_j)
      AST_EVEN_OFFSET: assert (imm_out[0] == 1'b0); // R3
    if (is_u)
      AST_UPPER_LOW_ZERO: assert (imm_out[11:0] == 12'd0 && imm_out[31:12] == instr_word[31:12]); // R5
    if (fmt_sel > FMT_J)
      AST_UNUSED_ZERO: assert (imm_out == 32'd0); // R7
    if (signed_fmt)
      AST_SHARED_MID: assert (imm_out[10:5] == instr_word[30:25]); // R9
    if (is_b)
      AST_BRANCH_B11: assert (imm_out[11] == instr_word[7]); // R3
    if (is_j)
      AST_JUMP_B11: assert (imm_out[11] == instr_word[20] && imm_out[19:12] == instr_word[19:12]); // R4
  end

endmodule

// File: tb/imm_extract_tb_top.sv
module imm_extract_tb_top;

  logic        clk = 1'b0;
  logic [31:0] instr_word;
  logic [2:0]  fmt_sel;
  logic [31:0] imm_out;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  imm_extract dut_i (
    .instr_word(instr_word),
    .fmt_sel   (fmt_sel),
    .imm_out   (imm_out)
  );

  function automatic logic [31:0] ref_imm(input logic [31:0] w, input logic [2:0] f);
    case (f)
      3'd0:    ref_imm = {{20{w[31]}}, w[31:20]};
      3'd1:    ref_imm = {{20{w[31]}}, w[31:25], w[11:7]};
      3'd2:    ref_imm = {{20{w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
      3'd3:    ref_imm = {w[31:12], 12'd0};
      3'd4:    ref_imm = {{12{w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
      default: ref_imm = 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0:    req_of = "R1";
      3'd1:    req_of = "R2";
      3'd2:    req_of = "R3";
      3'd3:    req_of = "R5";
      3'd4:    req_of = "R4";
      default: req_of = "R7";
    endcase
  endfunction

  task automatic apply_check(input logic [31:0] w, input logic [2:0] f,
                             input logic [31:0] exp, input string req);
    @(negedge clk);
    instr_word = w;
    fmt_sel    = f;
    #1;
    n_checks++;
    if (imm_out !== exp) begin
      n_errors++;
      $display("FAIL %s: word=%h fmt=%0d actual=%h expected=%h", req, w, f, imm_out, exp);
    end
  endtask

  task automatic ref_check(input logic [31:0] w, input logic [2:0] f);
    apply_check(w, f, ref_imm(w, f), req_of(f));
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_errors++;
      $display("FAIL R8: watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w;
    logic [2:0]  f;
    void'($urandom(32'd1234));
    instr_word = 32'd0;
    fmt_sel    = 3'd0;

    apply_check(32'h0000_0000, 3'd0, 32'h0000_0000, "R8");
    apply_check(32'h7FF0_0000, 3'd0, 32'h0000_07FF, "R1");
    apply_check(32'h8000_0000, 3'd0, 32'hFFFF_F800, "R1");
    apply_check(32'hFE00_0F80, 3'd1, 32'hFFFF_FFFF, "R2");
    apply_check(32'h01F0_0000, 3'd1, 32'h0000_0000, "R2");
    apply_check(32'h7E00_0F80, 3'd2, 32'h0000_0FFE, "R3");
    apply_check(32'h8000_0000, 3'd2, 32'hFFFF_F000, "R3");
    apply_check(32'h0000_0080, 3'd2, 32'h0000_0800, "R3");
    apply_check(32'h7FFF_F000, 3'd4, 32'h000F_FFFE, "R4");
    apply_check(32'h8000_0000, 3'd4, 32'hFFF0_0000, "R4");
    apply_check(32'h0010_0000, 3'd4, 32'h0000_0800, "R4");
    apply_check(32'hFFFF_FFFF, 3'd3, 32'hFFFF_F000, "R5");
    apply_check(32'h1234_5FFF, 3'd3, 32'h1234_5000, "R5");
    apply_check(32'h8000_0000, 3'd1, 32'hFFFF_F800, "R6");
    apply_check(32'h7E00_0000, 3'd0, 32'h0000_07E0, "R9");
    apply_check(32'h7E00_0000, 3'd4, 32'h0000_07E0, "R9");
    apply_check(32'hFFFF_FFFF, 3'd5, 32'h0000_0000, "R7");
    apply_check(32'hFFFF_FFFF, 3'd6, 32'h0000_0000, "R7");
    apply_check(32'hA5A5_A5A5, 3'd7, 32'h0000_0000, "R7");
    apply_check(32'hFFFF_FFFF, 3'd0, 32'hFFFF_FFFF, "R8");

    for (int i = 0; i < 600; i++) begin
      w = $urandom;
      f = 3'($urandom % 8);
      ref_check(w, f);
    end
    for (int k = 0; k < 8; k++) begin
      ref_check(32'h5555_5555, 3'(k));
      ref_check(32'hAAAA_AAAA, 3'(k));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule